// File: doc/BRIEF.md
# Instruction Decoder with Register File

This block sits between instruction fetch and execute in a non-pipelined 32-bit integer core. It takes one instruction word and drives three kinds of output. The first is the control for the execute stage, which is a one-hot operation class, an ALU operation code, a branch condition code and two operand-select bits. The second is a sign-extended immediate. The third is the contents of the two source registers. The control outputs and the immediate are combinational in the instruction word. The register values come out of a 32 x 32-bit register file that has two read ports, and they appear one clock after the instruction that names them.

The same instruction word also supplies the destination address for write-back. The write-back stage presents a value and an enable. The write lands in the destination register only when the decoded class is one that produces a result. Instructions outside the supported subset decode to an all-zero class, so they can never disturb architectural state. A write to a register that is being read in the same cycle is forwarded to the read output.

Top module: `instr_decode_unit`

## Requirements
- R1: `op_class_o` has at most one bit set. The bit positions are: bit 0 register or immediate arithmetic, bit 1 store, bit 2 load, bit 3 branch, bit 4 jump.
- R2: `alu_op_o` uses the codes 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right and 7 arithmetic shift right. The code is picked by func3 (bits [14:12]). Bit 30 selects subtract over add in the register form only, and it selects the arithmetic right shift in both forms. Loads, stores, branches and jumps give add.
- R3: `cond_op_o` equals func3 for a branch (0 eq, 1 ne, 4 lt, 5 ge, 6 ltu, 7 geu). It is 0 for every other instruction.
- R4: `a_sel_o` is 1 (rs1) for arithmetic, load, store and jump, and 0 (PC) for branch. `b_sel_o` is 1 (rs2) only for register-register arithmetic. It is 0 (immediate) otherwise.
- R5: Immediate arithmetic (opcode 0010011), word load (0000011) and indirect jump (1100111) output bits [31:20] sign-extended. Register-register arithmetic (0110011) outputs immediate 0.
- R6: A word store (0100011) outputs the 12-bit value {bits[31:25], bits[11:7]}, sign-extended from bit 31.
- R7: A branch (1100011) outputs the 13-bit value {bit31, bit7, bits[30:25], bits[11:8], 0}, sign-extended, so bit 0 is always 0.
- R8: The following decode to class 0 with every other control output and the immediate at 0: any other opcode, arithmetic func3 2 or 3, a load or store with func3 other than 2, a branch with func3 2 or 3, and a jump with func3 other than 0.
- R9: One clock after an instruction is presented, `rs1_data_o` and `rs2_data_o` hold the registers addressed by bits [19:15] and [24:20].
- R10: Register 0 always reads as zero, and writes to it are discarded.
- R11: Register bits [11:7] is written with `wb_data_i` on a clock edge only when `wb_en_i` is 1 and the class is arithmetic, load or jump. Stores, branches and unsupported words never write.
- R12: A write that targets a register being read in the same cycle shows its new value on the read output at that same edge.
- R13: While `rst_n` is low at a clock edge, every register and both read outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 32 | Instruction word to decode |
| wb_en_i | input | 1 | Write-back enable |
| wb_data_i | input | 32 | Write-back value |
| rs1_data_o | output | 32 | Registered first source register value |
| rs2_data_o | output | 32 | Registered second source register value |
| imm_o | output | 32 | Sign-extended immediate |
| op_class_o | output | 5 | One-hot operation class |
| alu_op_o | output | 3 | ALU operation code |
| cond_op_o | output | 3 | Branch condition code |
| a_sel_o | output | 1 | Operand A select (0 PC, 1 rs1) |
| b_sel_o | output | 1 | Operand B select (0 immediate, 1 rs2) |

## Verification
The register file has no port of its own, so its state is hard to reach. Every write and every read must be expressed as an instruction word, and the destination field of a store word carries immediate bits rather than an address. The stimulus therefore builds its own instruction words. To show that a blocked write left a register untouched, it sends a store whose immediate low bits name that register, then a read instruction that names the same register. The forwarding case needs a single instruction whose destination equals one of its sources while the enable is high, and the stimulus issues exactly that.

// File: rtl/idu_pkg.sv
// Shared constants and types for the instruction decode unit.
// Assumes 32-bit instruction words with the standard field positions.
package idu_pkg;
    localparam int ILEN  = 32;
    localparam int CLS_W = 5;

    // Bit positions inside the one-hot operation class
    localparam int CLS_ARITH  = 0;
    localparam int CLS_STORE  = 1;
    localparam int CLS_LOAD   = 2;
    localparam int CLS_BRANCH = 3;
    localparam int CLS_JUMP   = 4;

    localparam logic [CLS_W-1:0] CLS_WRITES_RD =
        CLS_W'((1 << CLS_ARITH) | (1 << CLS_LOAD) | (1 << CLS_JUMP));

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;

    localparam logic [2:0] F3_WORD = 3'b010;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_XOR = 3'd4,
        ALU_SLL = 3'd5,
        ALU_SRL = 3'd6,
        ALU_SRA = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_ZERO = 2'd0,
        IMM_I    = 2'd1,
        IMM_S    = 2'd2,
        IMM_B    = 2'd3
    } imm_fmt_e;

    typedef struct packed {
        logic [CLS_W-1:0] cls;
        alu_op_e          alu;
        logic [2:0]       cond;
        logic             a_sel;
        logic             b_sel;
        imm_fmt_e         fmt;
    } ctrl_t;
endpackage

// File: rtl/idu_ctrl.sv
// Control decoder: turns opcode, func3 and bit 30 into the execute-stage
// controls and the immediate format. Purely combinational. Any word
// outside the supported subset yields all-zero controls.
module idu_ctrl
    import idu_pkg::*;
(
    input  logic [ILEN-1:0] instr_i,
    output ctrl_t           ctrl_o
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic       b30;
    alu_op_e    base_alu;
    logic       arith_ok;

    assign opc = instr_i[6:0];
    assign f3  = instr_i[14:12];
    assign b30 = instr_i[30];

    // Map func3 to an ALU code common to both arithmetic forms
    always_comb begin
        arith_ok = 1'b1;
        base_alu = ALU_ADD;
        case (f3)
            3'b000:  base_alu = ALU_ADD;
            3'b001:  base_alu = ALU_SLL;
            3'b100:  base_alu = ALU_XOR;
            3'b101:  base_alu = b30 ? ALU_SRA : ALU_SRL;
            3'b110:  base_alu = ALU_OR;
            3'b111:  base_alu = ALU_AND;
            default: arith_ok = 1'b0;
        endcase
    end

    // Select class, operand routing and immediate format per opcode
    always_comb begin
        ctrl_o = '0;
        case (opc)
            OPC_REG: begin
                if (arith_ok) begin
                    ctrl_o.cls[CLS_ARITH] = 1'b1;
                    ctrl_o.alu   = (f3 == 3'b000 && b30) ? ALU_SUB : base_alu;
                    ctrl_o.a_sel = 1'b1;
                    ctrl_o.b_sel = 1'b1;
                    ctrl_o.fmt   = IMM_ZERO;
                end
            end
            OPC_IMM: begin
                if (arith_ok) begin
                    ctrl_o.cls[CLS_ARITH] = 1'b1;
                    ctrl_o.alu   = base_alu;
                    ctrl_o.a_sel = 1'b1;
                    ctrl_o.fmt   = IMM_I;
                end
            end
            OPC_LOAD: begin
                if (f3 == F3_WORD) begin
                    ctrl_o.cls[CLS_LOAD] = 1'b1;
                    ctrl_o.a_sel = 1'b1;
                    ctrl_o.fmt   = IMM_I;
                end
            end
            OPC_STORE: begin
                if (f3 == F3_WORD) begin
                    ctrl_o.cls[CLS_STORE] = 1'b1;
                    ctrl_o.a_sel = 1'b1;
                    ctrl_o.fmt   = IMM_S;
                end
            end
            OPC_BRANCH: begin
                if (f3[2:1] != 2'b01) begin
                    ctrl_o.cls[CLS_BRANCH] = 1'b1;
                    ctrl_o.cond = f3;
                    ctrl_o.fmt  = IMM_B;
                end
            end
            OPC_JALR: begin
                if (f3 == 3'b000) begin
                    ctrl_o.cls[CLS_JUMP] = 1'b1;
                    ctrl_o.a_sel = 1'b1;
                    ctrl_o.fmt   = IMM_I;
                end
            end
            default: ctrl_o = '0;
        endcase
    end
endmodule

// File: rtl/idu_imm.sv
// Immediate generator: assembles the immediate for the given format and
// sign-extends it from instruction bit 31 to XLEN bits. Combinational.
// Assumes XLEN is at least 13.
module idu_imm
    import idu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0] instr_i,
    input  imm_fmt_e        fmt_i,
    output logic [XLEN-1:0] imm_o
);
    localparam int EXT12 = XLEN - 12;
    localparam int EXT13 = XLEN - 13;

    logic sgn;
    assign sgn = instr_i[31];

    // Pick the bit arrangement of the selected format
    always_comb begin
        case (fmt_i)
            IMM_I:   imm_o = {{EXT12{sgn}}, instr_i[31:20]};
            IMM_S:   imm_o = {{EXT12{sgn}}, instr_i[31:25], instr_i[11:7]};
            IMM_B:   imm_o = {{EXT13{sgn}}, instr_i[31], instr_i[7],
                              instr_i[30:25], instr_i[11:8], 1'b0};
            default: imm_o = '0;
        endcase
    end
endmodule

// File: rtl/idu_regfile.sv
// Register file with one write port and NRD registered read ports.
// Entry 0 is hard zero. A write to an address being read in the same
// cycle is forwarded to that read output. Synchronous active-low reset
// clears storage and read outputs.
module idu_regfile #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32,
    parameter int NRD   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [$clog2(DEPTH)-1:0]   wa_i,
    input  logic [WIDTH-1:0]           wd_i,
    input  logic [NRD-1:0][$clog2(DEPTH)-1:0] ra_i,
    output logic [NRD-1:0][WIDTH-1:0]  rd_o
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic             wr_live;

    assign wr_live = we_i && (wa_i != '0);

    // Storage update: clear on reset, otherwise take the write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
        end else if (wr_live) begin
            mem[wa_i] <= wd_i;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [WIDTH-1:0] q_r;
        logic [AW-1:0]    addr;
        assign addr = ra_i[p];

        // Read register: zero for entry 0, forward a colliding write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_r <= '0;
            end else if (addr == '0) begin
                q_r <= '0;
            end else if (wr_live && (wa_i == addr)) begin
                q_r <= wd_i;
            end else begin
                q_r <= mem[addr];
            end
        end

        assign rd_o[p] = q_r;
    end
endmodule

// File: rtl/instr_decode_unit.sv
// Instruction decode unit: control decode, immediate generation and a
// two-read-port register file. Controls and immediate are combinational.
// Register values are registered (one cycle after the instruction).
// Write-back uses the rd field of the current instruction and is allowed
// only for result-producing classes.
module instr_decode_unit
    import idu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      instr_i,
    input  logic             wb_en_i,
    input  logic [XLEN-1:0]  wb_data_i,
    output logic [XLEN-1:0]  rs1_data_o,
    output logic [XLEN-1:0]  rs2_data_o,
    output logic [XLEN-1:0]  imm_o,
    output logic [4:0]       op_class_o,
    output logic [2:0]       alu_op_o,
    output logic [2:0]       cond_op_o,
    output logic             a_sel_o,
    output logic             b_sel_o
);
    localparam int RAW = $clog2(NREGS);

    ctrl_t                     ctrl;
    logic                      wr_en;
    logic [1:0][RAW-1:0]       rd_addr;
    logic [1:0][XLEN-1:0]      rd_data;

    idu_ctrl u_ctrl (
        .instr_i (instr_i),
        .ctrl_o  (ctrl)
    );

    idu_imm #(.XLEN(XLEN)) u_imm (
        .instr_i (instr_i),
        .fmt_i   (ctrl.fmt),
        .imm_o   (imm_o)
    );

    assign wr_en      = wb_en_i && ((ctrl.cls & CLS_WRITES_RD) != '0);
    assign rd_addr[0] = instr_i[15 +: RAW];
    assign rd_addr[1] = instr_i[20 +: RAW];

    idu_regfile #(.WIDTH(XLEN), .DEPTH(NREGS), .NRD(2)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (wr_en),
        .wa_i  (instr_i[7 +: RAW]),
        .wd_i  (wb_data_i),
        .ra_i  (rd_addr),
        .rd_o  (rd_data)
    );

    assign rs1_data_o = rd_data[0];
    assign rs2_data_o = rd_data[1];
    assign op_class_o = ctrl.cls;
    assign alu_op_o   = ctrl.alu;
    assign cond_op_o  = ctrl.cond;
    assign a_sel_o    = ctrl.a_sel;
    assign b_sel_o    = ctrl.b_sel;
endmodule

// File: rtl/instr_decode_unit_chk.sv
// Property checker for instr_decode_unit, attached by bind below.
// Observes ports only.
module instr_decode_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [31:0]     instr_i,
    input logic            wb_en_i,
    input logic [XLEN-1:0] wb_data_i,
    input logic [XLEN-1:0] rs1_data_o,
    input logic [XLEN-1:0] rs2_data_o,
    input logic [XLEN-1:0] imm_o,
    input logic [4:0]      op_class_o,
    input logic [2:0]      alu_op_o,
    input logic [2:0]      cond_op_o,
    input logic            a_sel_o,
    input logic            b_sel_o
);
    // R1
    class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_class_o));

    // R3
    cond_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_class_o[3] |-> (cond_op_o == 3'd0));

    // R4
    branch_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_class_o[3] |-> (!a_sel_o && !b_sel_o));

    // R7
    branch_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_class_o[3] |-> (imm_o[0] == 1'b0));

    // R8
    none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class_o == 5'd0) |-> (alu_op_o == 3'd0 && cond_op_o == 3'd0 &&
                                  !a_sel_o && !b_sel_o && imm_o == '0));

    // R10
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[19:15] == 5'd0) |=> (rs1_data_o == '0));

    // R12
    fwd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en_i && (op_class_o[0] || op_class_o[2] || op_class_o[4]) &&
         instr_i[11:7] != 5'd0 && instr_i[11:7] == instr_i[19:15])
        |=> (rs1_data_o == $past(wb_data_i)));

    // R13
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rs1_data_o == '0 && rs2_data_o == '0));
endmodule

bind instr_decode_unit instr_decode_unit_chk #(.XLEN(XLEN)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_i    (instr_i),
    .wb_en_i    (wb_en_i),
    .wb_data_i  (wb_data_i),
    .rs1_data_o (rs1_data_o),
    .rs2_data_o (rs2_data_o),
    .imm_o      (imm_o),
    .op_class_o (op_class_o),
    .alu_op_o   (alu_op_o),
    .cond_op_o  (cond_op_o),
    .a_sel_o    (a_sel_o),
    .b_sel_o    (b_sel_o)
);

// File: tb/instr_decode_unit_tb_top.sv
`timescale 1ns/1ps
// Bench for instr_decode_unit: a decode vector table, then directed
// register-file tests for write gating, forwarding, register 0 and reset.
module instr_decode_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr;
    logic        wb_en;
    logic [31:0] wb_data;
    logic [31:0] rs1_q, rs2_q, imm;
    logic [4:0]  cls;
    logic [2:0]  alu, cnd;
    logic        asel, bsel;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    instr_decode_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_i    (instr),
        .wb_en_i    (wb_en),
        .wb_data_i  (wb_data),
        .rs1_data_o (rs1_q),
        .rs2_data_o (rs2_q),
        .imm_o      (imm),
        .op_class_o (cls),
        .alu_op_o   (alu),
        .cond_op_o  (cnd),
        .a_sel_o    (asel),
        .b_sel_o    (bsel)
    );

    function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2,
            logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_i(logic [11:0] im, logic [4:0] rs1,
            logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
        return {im, rs1, f3, rd, opc};
    endfunction

    function automatic logic [31:0] enc_s(logic [11:0] im, logic [4:0] rs2,
            logic [4:0] rs1, logic [2:0] f3);
        return {im[11:5], rs2, rs1, f3, im[4:0], 7'b0100011};
    endfunction

    function automatic logic [31:0] enc_b(logic [12:0] off, logic [4:0] rs2,
            logic [4:0] rs1, logic [2:0] f3);
        return {off[12], off[10:5], rs2, rs1, f3, off[4:1], off[11], 7'b1100011};
    endfunction

    localparam logic [6:0] T_IMM  = 7'b0010011;
    localparam logic [6:0] T_LOAD = 7'b0000011;
    localparam logic [6:0] T_JMP  = 7'b1100111;

    typedef struct packed {
        logic [31:0] ins;
        logic [4:0]  cls;
        logic [2:0]  alu;
        logic [2:0]  cnd;
        logic        a;
        logic        b;
        logic [31:0] imm;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VT [NV] = '{
        '{enc_r(7'h00,5'd3,5'd2,3'd0,5'd1), 5'b00001, 3'd0, 3'd0, 1'b1, 1'b1, 32'h0, 4'd2},        // R2 add
        '{enc_r(7'h20,5'd3,5'd2,3'd0,5'd1), 5'b00001, 3'd1, 3'd0, 1'b1, 1'b1, 32'h0, 4'd2},        // R2 sub
        '{enc_r(7'h20,5'd3,5'd2,3'd5,5'd1), 5'b00001, 3'd7, 3'd0, 1'b1, 1'b1, 32'h0, 4'd2},        // R2 sra
        '{enc_r(7'h00,5'd3,5'd2,3'd7,5'd1), 5'b00001, 3'd2, 3'd0, 1'b1, 1'b1, 32'h0, 4'd4},        // R4 and
        '{enc_r(7'h20,5'd3,5'd2,3'd6,5'd1), 5'b00001, 3'd3, 3'd0, 1'b1, 1'b1, 32'h0, 4'd2},        // R2 or, bit30 ignored
        '{enc_i(12'hFFF,5'd4,3'd0,5'd6,T_IMM), 5'b00001, 3'd0, 3'd0, 1'b1, 1'b0, 32'hFFFFFFFF, 4'd5}, // R5
        '{enc_i(12'h7FF,5'd4,3'd4,5'd6,T_IMM), 5'b00001, 3'd4, 3'd0, 1'b1, 1'b0, 32'h000007FF, 4'd5}, // R5
        '{enc_i(12'h403,5'd4,3'd5,5'd6,T_IMM), 5'b00001, 3'd7, 3'd0, 1'b1, 1'b0, 32'h00000403, 4'd2}, // R2 srai
        '{enc_i(12'h01F,5'd4,3'd5,5'd6,T_IMM), 5'b00001, 3'd6, 3'd0, 1'b1, 1'b0, 32'h0000001F, 4'd2}, // R2 srli
        '{enc_i(12'h400,5'd4,3'd0,5'd6,T_IMM), 5'b00001, 3'd0, 3'd0, 1'b1, 1'b0, 32'h00000400, 4'd2}, // R2 addi bit30
        '{enc_i(12'h800,5'd1,3'd2,5'd3,T_LOAD), 5'b00100, 3'd0, 3'd0, 1'b1, 1'b0, 32'hFFFFF800, 4'd5}, // R5 load
        '{enc_s(12'h7F4,5'd5,5'd1,3'd2), 5'b00010, 3'd0, 3'd0, 1'b1, 1'b0, 32'h000007F4, 4'd6},      // R6
        '{enc_s(12'hFFC,5'd5,5'd1,3'd2), 5'b00010, 3'd0, 3'd0, 1'b1, 1'b0, 32'hFFFFFFFC, 4'd6},      // R6
        '{enc_b(13'h1FF0,5'd2,5'd1,3'd0), 5'b01000, 3'd0, 3'd0, 1'b0, 1'b0, 32'hFFFFFFF0, 4'd7},     // R7
        '{enc_b(13'h0FFE,5'd2,5'd1,3'd7), 5'b01000, 3'd0, 3'd7, 1'b0, 1'b0, 32'h00000FFE, 4'd7},     // R7
        '{enc_b(13'h0800,5'd2,5'd1,3'd1), 5'b01000, 3'd0, 3'd1, 1'b0, 1'b0, 32'h00000800, 4'd7},     // R7
        '{enc_b(13'h1000,5'd2,5'd1,3'd4), 5'b01000, 3'd0, 3'd4, 1'b0, 1'b0, 32'hFFFFF000, 4'd3},     // R3
        '{enc_i(12'h004,5'd3,3'd0,5'd1,T_JMP), 5'b10000, 3'd0, 3'd0, 1'b1, 1'b0, 32'h00000004, 4'd4}, // R4 jump
        '{32'h00000073, 5'b0, 3'd0, 3'd0, 1'b0, 1'b0, 32'h0, 4'd8},                                   // R8 system
        '{32'h0000000F, 5'b0, 3'd0, 3'd0, 1'b0, 1'b0, 32'h0, 4'd8},                                   // R8 fence
        '{enc_r(7'h00,5'd3,5'd2,3'd2,5'd1), 5'b0, 3'd0, 3'd0, 1'b0, 1'b0, 32'h0, 4'd8},             // R8 func3 2
        '{enc_i(12'h010,5'd1,3'd0,5'd3,T_LOAD), 5'b0, 3'd0, 3'd0, 1'b0, 1'b0, 32'h0, 4'd8},          // R8 byte load
        '{enc_b(13'h0010,5'd2,5'd1,3'd2), 5'b0, 3'd0, 3'd0, 1'b0, 1'b0, 32'h0, 4'd8},               // R8 branch f3 2
        '{enc_i(12'h004,5'd3,3'd1,5'd1,T_JMP), 5'b0, 3'd0, 3'd0, 1'b0, 1'b0, 32'h0, 4'd8},           // R8 jump f3 1
        '{32'h123452B7, 5'b0, 3'd0, 3'd0, 1'b0, 1'b0, 32'h0, 4'd8},                                   // R8 upper imm
        '{enc_s(12'h010,5'd5,5'd1,3'd0), 5'b0, 3'd0, 3'd0, 1'b0, 1'b0, 32'h0, 4'd8}                  // R8 byte store
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog got=running exp=done");
        report();
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        instr   = 32'h0;
        wb_en   = 1'b0;
        wb_data = 32'h0;
        step();
        step();
        // R13 reset state of the read outputs
        check("R13 reset rs1", {32'h0, rs1_q}, 64'h0);
        check("R13 reset rs2", {32'h0, rs2_q}, 64'h0);
        rst_n = 1'b1;

        // Decode table, combinational outputs sampled mid-cycle
        for (int v = 0; v < NV; v++) begin
            string tag;
            instr = VT[v].ins;
            #1;
            tag = $sformatf("R%0d vector %0d", VT[v].req, v);
            check(tag, {19'h0, cls, alu, cnd, asel, bsel, imm},
                       {19'h0, VT[v].cls, VT[v].alu, VT[v].cnd, VT[v].a, VT[v].b, VT[v].imm});
            // R1 at most one class bit
            check("R1 onehot", 64'($countones(cls) <= 1), 64'd1);
            @(negedge clk);
        end

        // R11 arithmetic write to x5, then R9 registered read of x5 on both ports
        instr = enc_i(12'h000, 5'd0, 3'd0, 5'd5, T_IMM); wb_en = 1'b1; wb_data = 32'hA5A50001;
        step();
        instr = enc_r(7'h00, 5'd5, 5'd5, 3'd0, 5'd0); wb_en = 1'b0;
        step();
        check("R9 rs1 x5", {32'h0, rs1_q}, {32'h0, 32'hA5A50001});
        check("R9 rs2 x5", {32'h0, rs2_q}, {32'h0, 32'hA5A50001});

        // R10 write to x0 is dropped
        instr = enc_i(12'h000, 5'd0, 3'd0, 5'd0, T_IMM); wb_en = 1'b1; wb_data = 32'hFFFF0000;
        step();
        instr = enc_r(7'h00, 5'd0, 5'd0, 3'd0, 5'd1); wb_en = 1'b0;
        step();
        check("R10 x0 read", {rs1_q, rs2_q}, 64'h0);

        // R11 store with rd-field bits = 6 does not write x6
        instr = enc_s(12'h006, 5'd5, 5'd1, 3'd2); wb_en = 1'b1; wb_data = 32'h12340006;
        step();
        // R11 enable low does not write x7
        instr = enc_i(12'h000, 5'd0, 3'd0, 5'd7, T_IMM); wb_en = 1'b0; wb_data = 32'h55550007;
        step();
        // R8 unsupported word with rd = 8 does not write x8
        instr = 32'h00000437; wb_en = 1'b1; wb_data = 32'h88880008;
        step();
        instr = enc_r(7'h00, 5'd7, 5'd6, 3'd0, 5'd0); wb_en = 1'b0;
        step();
        check("R11 store blocked x6", {32'h0, rs1_q}, 64'h0);
        check("R11 enable low x7", {32'h0, rs2_q}, 64'h0);
        instr = enc_r(7'h00, 5'd0, 5'd8, 3'd0, 5'd0);
        step();
        check("R8 unsupported no write x8", {32'h0, rs1_q}, 64'h0);

        // R12 forward: rd = rs1 = 9 in the write cycle
        instr = enc_r(7'h00, 5'd5, 5'd9, 3'd0, 5'd9); wb_en = 1'b1; wb_data = 32'hCAFE0009;
        step();
        check("R12 forwarded rs1", {32'h0, rs1_q}, {32'h0, 32'hCAFE0009});
        check("R12 other port rs2", {32'h0, rs2_q}, {32'h0, 32'hA5A50001});

        // R11 load and jump classes write
        instr = enc_i(12'h000, 5'd1, 3'd2, 5'd10, T_LOAD); wb_data = 32'h00000010;
        step();
        instr = enc_i(12'h004, 5'd1, 3'd0, 5'd11, T_JMP); wb_data = 32'h00000104;
        step();
        instr = enc_r(7'h00, 5'd11, 5'd10, 3'd0, 5'd0); wb_en = 1'b0;
        step();
        check("R11 load wrote x10", {32'h0, rs1_q}, {32'h0, 32'h00000010});
        check("R11 jump wrote x11", {32'h0, rs2_q}, {32'h0, 32'h00000104});

        // R13 reset clears outputs and storage
        rst_n = 1'b0;
        step();
        check("R13 outputs cleared", {rs1_q, rs2_q}, 64'h0);
        rst_n = 1'b1;
        instr = enc_r(7'h00, 5'd9, 5'd5, 3'd0, 5'd0);
        step();
        check("R13 storage cleared", {rs1_q, rs2_q}, 64'h0);

        report();
        $finish;
    end
endmodule